// File: doc/BRIEF.md
# Lockable Cache Way-Replacement Selector

This block decides where a line fill goes in a four-way set-associative cache. It receives one access per cycle: the set index, whether it was a hit and in which way, and whether it was a prefetch. On a miss it names a victim way and raises a fill enable in the same cycle. Hits and fills both refresh a per-set recency order, which is stored as a six-bit pairwise matrix.

A status-level lock enable switches on the locking rules. A small control register holds a load bit and a lock bit for ways 2 and 3. With locking on, a prefetch miss can be pinned to way 3 or way 2. Ordinary misses never evict a way whose lock bit is set. With locking off, the control bits do nothing and the plain recency order chooses the victim.

Each access is sorted into one decision class. The class has no memory and can change on any cycle.
- IDLE: no access this cycle.
- HIT: the access is a hit.
- PIN3: a prefetch miss where the way-3 pair qualifies.
- PIN2: a prefetch miss where the way-2 pair qualifies and the way-3 pair does not.
- LRU: every other miss.

Top module: `way_victim_sel`

## Requirements
- R1: After reset, every control bit reads 0 and every set holds way 0 as least recent. The first miss in any set therefore fills way 0.
- R2: In the control word, bit 9 is the way-3 load bit, bit 8 the way-3 lock bit, bit 1 the way-2 load bit and bit 0 the way-2 lock bit. These bits read back as written. Every other bit reads 0 whatever is written.
- R3: A hit never produces a fill. This holds for prefetch and ordinary hits, and whatever the control bits are.
- R4: A prefetch miss with the lock enable at 1 and both way-3 bits at 1 fills way 3.
- R5: A prefetch miss with the lock enable at 1, both way-2 bits at 1 and the way-3 pair not both 1 fills way 2. When both pairs qualify, way 3 wins.
- R6: Any other prefetch miss fills the least recent of all four ways.
- R7: An ordinary (non-prefetch) miss with the lock enable at 1 fills the least recent way among the ways whose lock bit is 0. Load bits have no effect on it.
- R8: With the lock enable at 0, the control bits have no effect, and every miss fills the least recent of all four ways.
- R9: Each hit, and each fill, makes that way the most recent of its own set. Other sets are left unchanged. Recency is a strict order over the four ways.
- R10: The fill enable and victim way follow the access inputs in the same cycle. With no valid access, the fill enable is 0.
- R11: A control write made in the same cycle as a miss does not affect that miss. The new bits govern from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_mode | input | 1 | Locking rules enable, taken from the status word |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Control register read data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_pref | input | 1 | The access is a prefetch |
| acc_hit | input | 1 | The access hit |
| acc_hit_way | input | 2 | Way that hit |
| acc_set | input | SET_W | Set index of the access (4 bits at the default 16 sets) |
| fill_en | output | 1 | A line fill takes place this cycle |
| fill_way | output | 2 | Way that receives the fill |

## Verification
Two events can land on the same clock edge: a control-register write, and a miss whose victim depends on those very bits. The bench provokes this directly by writing a way-3 pin while a prefetch miss is presented. It expects the victim to come from the old bits in that cycle and from the new bits on the following miss. Random runs also mix control writes into streams of accesses. Each victim is judged against a reference model that keeps its own recency state, built from time stamps rather than a pairwise matrix.

// File: rtl/wvs_pkg.sv
`timescale 1ns/1ps
package wvs_pkg;
    localparam int WAYS   = 4;
    localparam int PAIR_W = WAYS * (WAYS - 1) / 2;
    localparam int IDX_W  = $clog2(PAIR_W);

    typedef logic [PAIR_W-1:0] pair_t;

    typedef struct packed {
        logic w3_load;
        logic w3_lock;
        logic w2_load;
        logic w2_lock;
    } lockctl_t;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_HIT,
        CH_PIN3,
        CH_PIN2,
        CH_LRU
    } choice_e;

    // position of ordered pair (i<j) inside the matrix
    function automatic logic [IDX_W-1:0] pair_idx(input int i, input int j);
        return IDX_W'(i * WAYS - (i * (i + 1)) / 2 + (j - i - 1));
    endfunction

    // bit set means the lower way was used after the higher one
    function automatic logic older(input pair_t s, input int a, input int b);
        if (a < b) return !s[pair_idx(a, b)];
        else       return s[pair_idx(b, a)];
    endfunction

    function automatic pair_t touch(input pair_t s, input int w);
        pair_t r;
        r = s;
        for (int i = 0; i < WAYS; i++) begin
            for (int j = i + 1; j < WAYS; j++) begin
                if (i == w)      r[pair_idx(i, j)] = 1'b1;
                else if (j == w) r[pair_idx(i, j)] = 1'b0;
            end
        end
        return r;
    endfunction

    function automatic logic [1:0] pick_lru(input pair_t s, input logic [WAYS-1:0] cand);
        logic [1:0] r;
        logic       found;
        logic       ok;
        r     = 2'd0;
        found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (cand[w] && !found) begin
                ok = 1'b1;
                for (int k = 0; k < WAYS; k++) begin
                    if (k != w && cand[k] && !older(s, w, k)) ok = 1'b0;
                end
                if (ok) begin
                    r     = 2'(w);
                    found = 1'b1;
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/wvs_ctrl_reg.sv
`timescale 1ns/1ps
module wvs_ctrl_reg
    import wvs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  lockctl_t    wr_bits,
    output lockctl_t    ctl_q,
    output logic [31:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= wr_bits;
        end
    end

    always_comb begin
        rdata    = '0;
        rdata[9] = ctl_q.w3_load;
        rdata[8] = ctl_q.w3_lock;
        rdata[1] = ctl_q.w2_load;
        rdata[0] = ctl_q.w2_lock;
    end
endmodule

// File: rtl/wvs_lru_store.sv
`timescale 1ns/1ps
module wvs_lru_store
    import wvs_pkg::*;
#(
    parameter int SETS  = 16,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output pair_t            rd_state,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [1:0]       upd_way
);
    pair_t lru_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
        end else if (upd_en) begin
            lru_q[upd_set] <= touch(lru_q[upd_set], int'(upd_way));
        end
    end

    assign rd_state = lru_q[rd_set];
endmodule

// File: rtl/wvs_victim_pick.sv
`timescale 1ns/1ps
module wvs_victim_pick
    import wvs_pkg::*;
(
    input  logic       lock_mode,
    input  lockctl_t   ctl,
    input  logic       acc_valid,
    input  logic       acc_pref,
    input  logic       acc_hit,
    input  pair_t      lru_state,
    output choice_e    choice,
    output logic       fill_en,
    output logic [1:0] fill_way
);
    logic [WAYS-1:0] cand;
    logic [1:0]      lru_way;
    logic            pin3_ok;
    logic            pin2_ok;

    assign pin3_ok = acc_pref && lock_mode && ctl.w3_lock && ctl.w3_load;
    assign pin2_ok = acc_pref && lock_mode && ctl.w2_lock && ctl.w2_load;

    always_comb begin
        if (lock_mode && !acc_pref) cand = {~ctl.w3_lock, ~ctl.w2_lock, 2'b11};
        else                        cand = '1;
    end

    assign lru_way = pick_lru(lru_state, cand);

    always_comb begin
        if (!acc_valid)   choice = CH_IDLE;
        else if (acc_hit) choice = CH_HIT;
        else if (pin3_ok) choice = CH_PIN3;
        else if (pin2_ok) choice = CH_PIN2;
        else              choice = CH_LRU;
    end

    always_comb begin
        unique case (choice)
            CH_IDLE, CH_HIT: begin
                fill_en  = 1'b0;
                fill_way = 2'd0;
            end
            CH_PIN3: begin
                fill_en  = 1'b1;
                fill_way = 2'd3;
            end
            CH_PIN2: begin
                fill_en  = 1'b1;
                fill_way = 2'd2;
            end
            CH_LRU: begin
                fill_en  = 1'b1;
                fill_way = lru_way;
            end
            default: begin
                fill_en  = 1'b0;
                fill_way = 2'd0;
            end
        endcase
    end
endmodule

// File: rtl/way_victim_sel.sv
`timescale 1ns/1ps
module way_victim_sel
    import wvs_pkg::*;
#(
    parameter int SETS  = 16,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_mode,
    input  logic             csr_we,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    input  logic             acc_valid,
    input  logic             acc_pref,
    input  logic             acc_hit,
    input  logic [1:0]       acc_hit_way,
    input  logic [SET_W-1:0] acc_set,
    output logic             fill_en,
    output logic [1:0]       fill_way
);
    lockctl_t   ctl_q;
    lockctl_t   wr_bits;
    pair_t      cur_state;
    choice_e    choice;
    logic       upd_en;
    logic [1:0] upd_way;
    logic       unused_wbits;

    assign wr_bits      = '{w3_load: csr_wdata[9], w3_lock: csr_wdata[8],
                            w2_load: csr_wdata[1], w2_lock: csr_wdata[0]};
    assign unused_wbits = ^{csr_wdata[31:10], csr_wdata[7:2]};

    wvs_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (csr_we),
        .wr_bits (wr_bits),
        .ctl_q   (ctl_q),
        .rdata   (csr_rdata)
    );

    wvs_lru_store #(.SETS(SETS)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (acc_set),
        .rd_state (cur_state),
        .upd_en   (upd_en),
        .upd_set  (acc_set),
        .upd_way  (upd_way)
    );

    wvs_victim_pick u_pick (
        .lock_mode (lock_mode),
        .ctl       (ctl_q),
        .acc_valid (acc_valid),
        .acc_pref  (acc_pref),
        .acc_hit   (acc_hit),
        .lru_state (cur_state),
        .choice    (choice),
        .fill_en   (fill_en),
        .fill_way  (fill_way)
    );

    assign upd_en  = (choice == CH_HIT) || fill_en;
    assign upd_way = (choice == CH_HIT) ? acc_hit_way : fill_way;
endmodule

// File: rtl/wvs_checker.sv
`timescale 1ns/1ps
module wvs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lock_mode,
    input logic        csr_we,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        acc_valid,
    input logic        acc_pref,
    input logic        acc_hit,
    input logic        fill_en,
    input logic [1:0]  fill_way
);
    AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |-> !fill_en); // R3

    AST_PIN_WAY3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && acc_pref && lock_mode && csr_rdata[9] && csr_rdata[8])
        |-> (fill_en && fill_way == 2'd3)); // R4

    AST_LOCK_SHIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && !acc_pref && lock_mode && csr_rdata[8])
        |-> (fill_en && fill_way != 2'd3)); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata & ~32'h0000_0303) == 32'd0); // R2

    AST_IDLE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !fill_en); // R10

    AST_CSR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> (csr_rdata == ($past(csr_wdata) & 32'h0000_0303))); // R11
endmodule

bind way_victim_sel wvs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_mode (lock_mode),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .acc_valid (acc_valid),
    .acc_pref  (acc_pref),
    .acc_hit   (acc_hit),
    .fill_en   (fill_en),
    .fill_way  (fill_way)
);

// File: tb/way_victim_sel_test.sv
`timescale 1ns/1ps
module way_victim_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_mode = 1'b0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_pref = 1'b0;
    logic        acc_hit = 1'b0;
    logic [1:0]  acc_hit_way = '0;
    logic [3:0]  acc_set = '0;
    logic        fill_en;
    logic [1:0]  fill_way;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model: per-way use stamps and control bits
    int stamp [16][4];
    int tick;
    bit m_ld3, m_lk3, m_ld2, m_lk2;

    always #2.5 clk = ~clk;

    way_victim_sel uut (
        .clk(clk), .rst_n(rst_n), .lock_mode(lock_mode),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .acc_valid(acc_valid), .acc_pref(acc_pref), .acc_hit(acc_hit),
        .acc_hit_way(acc_hit_way), .acc_set(acc_set),
        .fill_en(fill_en), .fill_way(fill_way)
    );

    function automatic int exp_way(input bit lm, input bit pf, input int st);
        bit [3:0] cand;
        int best;
        if (pf && lm && m_ld3 && m_lk3) return 3;
        if (pf && lm && m_ld2 && m_lk2) return 2;
        cand = 4'hF;
        if (lm && !pf) begin
            if (m_lk3) cand[3] = 1'b0;
            if (m_lk2) cand[2] = 1'b0;
        end
        best = -1;
        for (int w = 0; w < 4; w++) begin
            if (cand[w] && (best < 0 || stamp[st][w] < stamp[st][best])) best = w;
        end
        return best;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) stamp[s][w] = w;
        tick = 4;
        {m_ld3, m_lk3, m_ld2, m_lk2} = 4'b0;
    endtask

    task automatic check_rd(input logic [31:0] exp, input string req);
        checks++;
        if (csr_rdata !== exp) begin
            failures++;
            $display("FAIL %s: csr_rdata=%h expected %h", req, csr_rdata, exp);
        end
    endtask

    task automatic csr_write(input logic [31:0] wd, input string req);
        @(negedge clk);
        acc_valid = 1'b0;
        csr_we = 1'b1;
        csr_wdata = wd;
        @(posedge clk);
        {m_ld3, m_lk3, m_ld2, m_lk2} = {wd[9], wd[8], wd[1], wd[0]};
        @(negedge clk);
        csr_we = 1'b0;
        #1;
        check_rd(wd & 32'h0000_0303, req);
    endtask

    task automatic access(input bit lm, input bit pf, input bit ht, input logic [1:0] hw,
                          input int st, input bit we, input logic [31:0] wd, input string req);
        int ew;
        bit ok;
        @(negedge clk);
        lock_mode = lm;
        acc_valid = 1'b1;
        acc_pref = pf;
        acc_hit = ht;
        acc_hit_way = hw;
        acc_set = 4'(st);
        csr_we = we;
        csr_wdata = wd;
        #1;
        ew = ht ? -1 : exp_way(lm, pf, st);
        checks++;
        ok = ht ? (fill_en === 1'b0) : (fill_en === 1'b1 && int'(fill_way) == ew);
        if (!ok) begin
            failures++;
            $display("FAIL %s: fill_en=%0d fill_way=%0d expected en=%0d way=%0d",
                     req, fill_en, fill_way, !ht, ew);
        end
        @(posedge clk);
        stamp[st][ht ? int'(hw) : ew] = tick;
        tick++;
        if (we) {m_ld3, m_lk3, m_ld2, m_lk2} = {wd[9], wd[8], wd[1], wd[0]};
    endtask

    task automatic go_idle();
        @(negedge clk);
        acc_valid = 1'b0;
        csr_we = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_rd(32'd0, "R1");
        access(1, 0, 0, 0, 5, 0, 0, "R1");
        access(0, 1, 0, 0, 6, 0, 0, "R1");

        // R2 field map and reserved bits
        csr_write(32'hFFFF_FFFF, "R2");
        csr_write(32'h0000_0202, "R2");
        csr_write(32'hA5A5_5A5A, "R2");

        // R4 pin to way 3, R3 hits give no fill
        csr_write(32'h0000_0300, "R4");
        access(1, 1, 0, 0, 1, 0, 0, "R4");
        access(1, 1, 0, 0, 1, 0, 0, "R4");
        access(1, 1, 1, 2'd0, 2, 0, 0, "R3");
        access(1, 0, 1, 2'd3, 2, 0, 0, "R3");
        access(1, 1, 0, 0, 2, 0, 0, "R3");

        // R5 way-2 pin and way-3 priority
        csr_write(32'h0000_0303, "R5");
        access(1, 1, 0, 0, 3, 0, 0, "R5");
        csr_write(32'h0000_0003, "R5");
        access(1, 1, 0, 0, 3, 0, 0, "R5");
        access(1, 1, 0, 0, 4, 0, 0, "R5");

        // R8 locking disabled
        csr_write(32'h0000_0303, "R8");
        access(0, 1, 0, 0, 10, 0, 0, "R8");
        access(0, 0, 0, 0, 10, 0, 0, "R8");
        access(0, 0, 0, 0, 10, 0, 0, "R8");
        access(0, 0, 0, 0, 10, 0, 0, "R8");

        // R6 unpinned prefetch misses; R7 locked ways shielded
        csr_write(32'h0000_0200, "R6");
        access(1, 1, 0, 0, 11, 0, 0, "R6");
        csr_write(32'h0000_0101, "R7");
        for (int i = 0; i < 5; i++) access(1, 0, 0, 0, 7, 0, 0, "R7");
        csr_write(32'h0000_0302, "R7");
        for (int i = 0; i < 4; i++) access(1, 0, 0, 0, 12, 0, 0, "R7");
        access(1, 1, 0, 0, 12, 0, 0, "R6");

        // R9 recency from hits
        csr_write(32'h0, "R9");
        access(1, 0, 1, 2'd0, 8, 0, 0, "R9");
        access(1, 0, 1, 2'd1, 8, 0, 0, "R9");
        access(1, 0, 1, 2'd3, 8, 0, 0, "R9");
        access(1, 0, 0, 0, 8, 0, 0, "R9");
        access(1, 0, 0, 0, 8, 0, 0, "R9");

        // R10 no access gives no fill
        go_idle();
        #1;
        checks++;
        if (fill_en !== 1'b0) begin
            failures++;
            $display("FAIL R10: fill_en=%0d expected 0", fill_en);
        end

        // R11 write in the same cycle as a miss
        access(1, 1, 0, 0, 9, 1, 32'h0000_0300, "R11");
        access(1, 1, 0, 0, 9, 0, 0, "R11");
        access(1, 0, 0, 0, 9, 1, 32'h0000_0101, "R11");
        access(1, 0, 0, 0, 9, 0, 0, "R11");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            bit we;
            logic [31:0] wd;
            we = ($urandom % 12) == 0;
            wd = $urandom;
            access(1'($urandom % 4 != 0), 1'($urandom), 1'($urandom % 5 < 2),
                   2'($urandom), int'($urandom % 4), we, wd, "R9");
        end
        go_idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule